// File: doc/BRIEF.md
# Frame Word to RGB Pixel Unpacker

This block sits between a frame-buffer fetch engine and a display timing path. It accepts 32-bit memory words on a valid/ready stream. Each time the timing path raises `active_in`, it emits one 24-bit RGB pixel. A two-bit run-time format code chooses how each word is cut into pixels:

- four 8-bit indices, each looked up in a 256-entry colour table;
- two 16-bit pixels in 5-6-5 layout, each widened to 8 bits per channel;
- one true-colour pixel.

A fourth code blanks the display.

The colour table is loaded through a single write port. Every write word carries both the entry number and the colour. Pixels inside a word are taken most-significant first. The output path has a fixed two-cycle latency in every format, so that the one-cycle table read lines up with the delayed active-video flag. If a pixel is requested while no word is held, the block emits black and sets a sticky underrun flag.

The word holder is a two-state machine:

- `BUF_EMPTY`: no word is held and `word_ready` is high. The *load* transition accepts a word and moves to `BUF_FULL`.
- `BUF_FULL`: requested pixels are served from the held word, advancing a slot counter. When the last slot is served, the machine either takes the next word in the same cycle (the *refill* transition, staying in `BUF_FULL`) or goes back to `BUF_EMPTY` (the *drain* transition).

Top module: `pixfmt_unpacker`

## Requirements
- R1: After reset, `pix_active_out` is 0, `pix_rgb` is 0 and `underrun` is 0. With format code 1, 2 or 3, `word_ready` is 1.
- R2: Format code 1: each word gives four pixels, taken from bits 31:24, then 23:16, then 15:8, then 7:0. Each byte is replaced by the colour-table entry it indexes.
- R3: A table write (`pal_wr_en`=1) stores entry `pal_wr_data[31:24]` with red from bits 23:16, green from bits 15:8 and blue from bits 7:0. `pix_rgb` is {red, green, blue}.
- R4: Format code 2: each word gives two pixels, bits 31:16 first, then bits 15:0. Within a 16-bit pixel, red is 15:11, green is 10:5 and blue is 4:0. Each channel is widened as {r,r[4:2]}, {g,g[5:4]} and {b,b[4:2]}.
- R5: Format code 3: each word gives one pixel equal to bits 23:0. Bits 31:24 have no effect on the output.
- R6: Format code 0: every requested pixel is black, `word_ready` stays 0, no word is consumed and `underrun` does not rise.
- R7: `pix_active_out` equals `active_in` two clock cycles earlier. `pix_rgb` is 0 whenever `pix_active_out` is 0.
- R8: A pixel requested with no word held (format code not 0) comes out black and sets `underrun`. `underrun` stays set until reset.
- R9: A word is consumed after 4, 2 or 1 pixels (codes 1, 2, 3). When the last slot is served and a new word is offered in the same cycle, it is taken with no gap.
- R10: When a table entry is written in the same cycle as a pixel reads that entry, the pixel gets the old colour. Later pixels get the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_mode | input | 2 | Format code: 0 blank, 1 indexed 8-bit, 2 packed 5-6-5, 3 true colour |
| pal_wr_en | input | 1 | Colour-table write strobe |
| pal_wr_data | input | 32 | Table write word {index, red, green, blue} |
| word_valid | input | 1 | Frame word offered |
| word_data | input | 32 | Frame word |
| word_ready | output | 1 | Block takes the offered word this cycle |
| active_in | input | 1 | A pixel is needed this cycle |
| pix_active_out | output | 1 | Active-video flag aligned with `pix_rgb` |
| pix_rgb | output | 24 | Output pixel {red, green, blue} |
| underrun | output | 1 | Sticky: a pixel was needed with no word held |

## Verification
Each non-blank format is driven with random words, random gaps in `active_in` and table writes scattered through the stream.

- The gaps separate the slot counter's advance from the cycle count.
- The table writes hit entries that are being read, which exposes the read-old-value ordering.
- Random top bytes in true-colour words show whether bits that should be ignored leak through.
- Counting accepted words tells whether the refill happens without a bubble.

Directed runs cover the blank format, which must consume nothing, and a request with an empty holder, which must give a black pixel, a sticky flag and the two-cycle active delay.

// File: rtl/pix_pkg.sv
package pix_pkg;
    localparam int WORD_W = 32;
    localparam int CH_W   = 8;
    localparam int PIX_W  = 3 * CH_W;

    typedef enum logic [1:0] {
        FMT_BLANK  = 2'd0,
        FMT_IDX8   = 2'd1,
        FMT_RGB565 = 2'd2,
        FMT_RGB888 = 2'd3
    } fmt_e;

    typedef enum logic {
        BUF_EMPTY = 1'b0,
        BUF_FULL  = 1'b1
    } buf_state_e;

    typedef enum logic [1:0] {
        SRC_BLACK  = 2'd0,
        SRC_DIRECT = 2'd1,
        SRC_TABLE  = 2'd2
    } src_e;

    function automatic logic [1:0] last_slot_of(input fmt_e f);
        unique case (f)
            FMT_IDX8:   return 2'd3;
            FMT_RGB565: return 2'd1;
            default:    return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/pix_word_buf.sv
module pix_word_buf
    import pix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              take,
    output logic              word_ready,
    output logic [WORD_W-1:0] held_word,
    output logic [1:0]        slot,
    output logic              have_word
);
    buf_state_e state_q, state_d;
    logic       last_slot;
    logic       serve;
    logic       accept;

    assign have_word  = (state_q == BUF_FULL);
    assign last_slot  = (slot == last_slot_of(fmt));
    assign serve      = take && have_word;
    assign word_ready = (fmt != FMT_BLANK) &&
                        ((state_q == BUF_EMPTY) || (serve && last_slot));
    assign accept     = word_ready && word_valid;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUF_EMPTY: if (accept) state_d = BUF_FULL;            // load
            BUF_FULL:  if (serve && last_slot)
                           state_d = accept ? BUF_FULL : BUF_EMPTY; // refill / drain
            default:   state_d = BUF_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BUF_EMPTY;
        else        state_q <= state_d;
    end

    // held word and slot pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            slot      <= '0;
        end else if (accept) begin
            held_word <= word_data;
            slot      <= '0;
        end else if (serve) begin
            slot      <= slot + 2'd1;
        end
    end
endmodule

// File: rtl/pix_slot_decode.sv
module pix_slot_decode
    import pix_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  fmt_e              fmt,
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        slot,
    output src_e              src,
    output logic [PIX_W-1:0]  direct_rgb,
    output logic [IDX_W-1:0]  tbl_idx
);
    localparam int LANES = WORD_W / 8;

    logic [7:0]  lane [LANES];
    logic [15:0] half;
    logic [4:0]  r5;
    logic [5:0]  g6;
    logic [4:0]  b5;

    // lane 0 is the most significant byte (first pixel)
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[WORD_W-1-8*i -: 8];
    end

    assign half = slot[0] ? word[15:0] : word[31:16];
    assign r5   = half[15:11];
    assign g6   = half[10:5];
    assign b5   = half[4:0];

    always_comb begin
        src        = SRC_BLACK;
        direct_rgb = '0;
        tbl_idx    = IDX_W'(lane[slot]);
        unique case (fmt)
            FMT_IDX8:   src = SRC_TABLE;
            FMT_RGB565: begin
                src        = SRC_DIRECT;
                direct_rgb = {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
            end
            FMT_RGB888: begin
                src        = SRC_DIRECT;
                direct_rgb = word[PIX_W-1:0];
            end
            default:    src = SRC_BLACK;
        endcase
    end
endmodule

// File: rtl/pix_palette.sv
module pix_palette
    import pix_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PIX_W-1:0]  rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    logic [PIX_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0] wr_idx;

    assign wr_idx = wr_word[WORD_W-1 -: IDX_W];

    // read-first: a same-cycle write is seen by the next read only
    always_ff @(posedge clk) begin
        if (rd_en) rd_rgb <= mem[rd_idx];
        if (wr_en) mem[wr_idx] <= wr_word[PIX_W-1:0];
    end
endmodule

// File: rtl/pixfmt_unpacker.sv
module pixfmt_unpacker
    import pix_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  fmt_mode,
    input  logic        pal_wr_en,
    input  logic [31:0] pal_wr_data,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    output logic        word_ready,
    input  logic        active_in,
    output logic        pix_active_out,
    output logic [23:0] pix_rgb,
    output logic        underrun
);
    fmt_e              fmt;
    logic              take;
    logic              have_word;
    logic              buf_empty;
    logic [WORD_W-1:0] held_word;
    logic [1:0]        slot;
    src_e              dec_src;
    logic [PIX_W-1:0]  dec_rgb;
    logic [IDX_W-1:0]  dec_idx;
    logic [PIX_W-1:0]  tbl_rgb;
    logic              tbl_rd;

    logic              s1_act;
    src_e              s1_src;
    logic [PIX_W-1:0]  s1_rgb;

    assign fmt       = fmt_e'(fmt_mode);
    assign take      = active_in && (fmt != FMT_BLANK);
    assign buf_empty = !have_word;
    assign tbl_rd    = take && have_word && (dec_src == SRC_TABLE);

    pix_word_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt),
        .word_valid (word_valid),
        .word_data  (word_data),
        .take       (take),
        .word_ready (word_ready),
        .held_word  (held_word),
        .slot       (slot),
        .have_word  (have_word)
    );

    pix_slot_decode #(.IDX_W(IDX_W)) u_dec (
        .fmt        (fmt),
        .word       (held_word),
        .slot       (slot),
        .src        (dec_src),
        .direct_rgb (dec_rgb),
        .tbl_idx    (dec_idx)
    );

    pix_palette #(.IDX_W(IDX_W)) u_pal (
        .clk     (clk),
        .wr_en   (pal_wr_en),
        .wr_word (pal_wr_data),
        .rd_en   (tbl_rd),
        .rd_idx  (dec_idx),
        .rd_rgb  (tbl_rgb)
    );

    // stage 1: pick the source of the pixel, flag starvation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_act   <= 1'b0;
            s1_src   <= SRC_BLACK;
            s1_rgb   <= '0;
            underrun <= 1'b0;
        end else begin
            s1_act   <= active_in;
            s1_src   <= (take && have_word) ? dec_src : SRC_BLACK;
            s1_rgb   <= dec_rgb;
            underrun <= underrun || (take && !have_word);
        end
    end

    // stage 2: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_active_out <= 1'b0;
            pix_rgb        <= '0;
        end else begin
            pix_active_out <= s1_act;
            if (!s1_act) begin
                pix_rgb <= '0;
            end else begin
                unique case (s1_src)
                    SRC_TABLE:  pix_rgb <= tbl_rgb;
                    SRC_DIRECT: pix_rgb <= s1_rgb;
                    default:    pix_rgb <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pix_unpacker_checker.sv
module pix_unpacker_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  fmt_mode,
    input logic        word_ready,
    input logic        active_in,
    input logic        pix_active_out,
    input logic [23:0] pix_rgb,
    input logic        underrun,
    input logic        buf_empty
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 3) age <= age + 2'd1;
    end

    a_r7_active_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (pix_active_out == $past(active_in, 2)));

    a_r7_black_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_active_out |-> (pix_rgb == 24'd0));

    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (active_in && fmt_mode != 2'd0 && buf_empty) |=> underrun);

    a_r8_black_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (active_in && fmt_mode != 2'd0 && buf_empty) |-> ##2 (pix_rgb == 24'd0));

    a_r6_blank_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_mode == 2'd0) |-> !word_ready);

    a_r6_blank_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_mode == 2'd0 && !underrun) |=> !underrun);

    a_r9_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && fmt_mode != 2'd0) |-> word_ready);
endmodule

bind pixfmt_unpacker pix_unpacker_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fmt_mode       (fmt_mode),
    .word_ready     (word_ready),
    .active_in      (active_in),
    .pix_active_out (pix_active_out),
    .pix_rgb        (pix_rgb),
    .underrun       (underrun),
    .buf_empty      (buf_empty)
);

// File: tb/pixfmt_unpacker_bench.sv
`timescale 1ns/1ps
module pixfmt_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_mode = 2'd1;
    logic        pal_wr_en = 1'b0;
    logic [31:0] pal_wr_data = '0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        active_in = 1'b0;
    logic        pix_active_out;
    logic [23:0] pix_rgb;
    logic        underrun;

    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc = 0;
    int          widx = 0;
    int          hs_cnt = 0;
    string       cur_tag = "R2";
    logic [23:0] exp_q[$];
    logic [23:0] pal_model [256];
    logic [31:0] words [64];

    always #2 clk = ~clk;

    pixfmt_unpacker u_pixfmt_unpacker (
        .clk(clk), .rst_n(rst_n), .fmt_mode(fmt_mode),
        .pal_wr_en(pal_wr_en), .pal_wr_data(pal_wr_data),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .active_in(active_in), .pix_active_out(pix_active_out),
        .pix_rgb(pix_rgb), .underrun(underrun)
    );

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            report();
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (pix_active_out) begin
                if (exp_q.size() == 0) check({cur_tag, " R7 unexpected pixel"}, 1, 0);
                else check({cur_tag, " pixel"}, {8'h0, pix_rgb}, {8'h0, exp_q.pop_front()});
            end else if (pix_rgb !== 24'd0) begin
                check("R7 idle black", {8'h0, pix_rgb}, 0);
            end
        end
    end

    function automatic logic [23:0] exp_pixel(input logic [1:0] m, input logic [31:0] w, input int s);
        logic [15:0] h;
        logic [7:0]  b;
        case (m)
            2'd1: begin
                b = w[31 - 8*s -: 8];
                return pal_model[b];
            end
            2'd2: begin
                h = (s == 0) ? w[31:16] : w[15:0];
                return {h[15:11], h[15:13], h[10:5], h[10:9], h[4:0], h[4:2]};
            end
            2'd3: return w[23:0];
            default: return 24'd0;
        endcase
    endfunction

    task automatic cycle(input bit act, input bit vld, input bit pwr,
                         input logic [31:0] pd, input logic [23:0] ex);
        bit hs;
        active_in   = act;
        word_valid  = vld;
        word_data   = words[widx];
        pal_wr_en   = pwr;
        pal_wr_data = pd;
        if (act) exp_q.push_back(ex);
        #1;
        hs = word_valid && word_ready;
        @(negedge clk);
        if (hs) begin
            widx++;
            hs_cnt++;
        end
        if (pwr) pal_model[pd[31:24]] = pd[23:0];
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n      = 1'b0;
        fmt_mode   = m;
        active_in  = 1'b0;
        word_valid = 1'b0;
        pal_wr_en  = 1'b0;
        widx       = 0;
        exp_q.delete();
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        hs_cnt = 0;
    endtask

    task automatic run_stream(input logic [1:0] m, input string tag);
        int spp;
        int k;
        logic [31:0] pd;
        spp = (m == 2'd1) ? 4 : (m == 2'd2) ? 2 : 1;
        cur_tag = tag;
        do_reset(m);
        for (int i = 0; i < 64; i++) words[i] = $urandom;
        for (int i = 0; i < 256; i++) cycle(0, 0, 1, {i[7:0], 24'($urandom)}, 0);
        hs_cnt = 0;
        cycle(0, 1, 0, 0, 0);                    // preload first word
        k = 0;
        while (k < 48) begin
            bit act;
            bit pwr;
            act = ($urandom % 4) != 0;
            pwr = ($urandom % 6) == 0;
            pd  = $urandom;
            // R10: sometimes overwrite the very entry being read now
            if (pwr && act && m == 2'd1 && ($urandom % 2) == 0)
                pd[31:24] = words[k / spp][31 - 8*(k % spp) -: 8];
            if (act) begin
                cycle(1, 1, pwr, pd, exp_pixel(m, words[k / spp], k % spp));
                k++;
            end else begin
                cycle(0, 1, pwr, pd, 0);
            end
        end
        repeat (4) cycle(0, 0, 0, 0, 0);
        check({tag, " R9 words taken"}, hs_cnt, 48 / spp + 1);
        check({tag, " R7 queue drained"}, exp_q.size(), 0);
        check({tag, " R8 no underrun when fed"}, underrun, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pal_model[i] = '0;
        for (int i = 0; i < 64; i++) words[i] = '0;
        void'($urandom(32'd1234));

        // R1 reset state
        do_reset(2'd1);
        @(negedge clk);
        check("R1 active_out", pix_active_out, 0);
        check("R1 rgb", pix_rgb, 0);
        check("R1 underrun", underrun, 0);
        check("R1 word_ready", word_ready, 1);

        // R2/R3/R10, R4, R5 random streams
        run_stream(2'd1, "R2 R3 R10");
        run_stream(2'd2, "R4");
        run_stream(2'd3, "R5");

        // R5 directed: top byte must not leak
        cur_tag = "R5";
        do_reset(2'd3);
        words[0] = 32'hFF123456;
        words[1] = 32'h00123456;
        cycle(0, 1, 0, 0, 0);
        cycle(1, 1, 0, 0, 24'h123456);
        cycle(1, 0, 0, 0, 24'h123456);
        repeat (3) cycle(0, 0, 0, 0, 0);

        // R6 blank format
        cur_tag = "R6";
        do_reset(2'd0);
        for (int i = 0; i < 6; i++) begin
            #1 check("R6 word_ready low", word_ready, 0);
            cycle(1, 1, 0, 0, 24'd0);
        end
        repeat (3) cycle(0, 0, 0, 0, 0);
        check("R6 no word consumed", hs_cnt, 0);
        check("R6 no underrun", underrun, 0);

        // R8 starvation and R7 latency
        cur_tag = "R8";
        do_reset(2'd3);
        words[0] = 32'h00ABCDEF;
        cycle(1, 0, 0, 0, 24'd0);
        check("R7 active_out after one edge", pix_active_out, 0);
        check("R8 underrun raised", underrun, 1);
        cycle(0, 1, 0, 0, 0);
        check("R7 active_out after two edges", pix_active_out, 1);
        check("R8 black on starvation", pix_rgb, 0);
        repeat (4) cycle(0, 1, 0, 0, 0);
        check("R8 underrun sticky", underrun, 1);

        report();
    end
endmodule